// File: doc/BRIEF.md
# DMA Global Register and Interrupt Control

This block is the shared register page of a multi-channel DMA copy engine. Software reads two constant bytes that describe the engine: how many channels it has and what transfers it can do. It also controls one interrupt through a master enable bit, and collects attention events from every channel in a 32-bit status word. The channels signal attention with one-cycle pulses. The block ORs each pulse into the status word and raises its interrupt line while the master enable is on and any status bit is set.

Both readable control registers have side effects. Reading the interrupt-control byte returns its value and turns the master enable off. Reading the status word returns it and clears it on the same clock edge. An attention pulse that lands on that edge is kept. Every access has to use exactly the size that its register defines. A wrong size, an unmapped offset, a write to a read-only register, or a read and a write in the same cycle each raise an error flag and change nothing. Data travels little-endian: a register's least significant byte is in `rdata[7:0]` or `wdata[7:0]`.

Accesses are sampled on the rising clock edge. `rdata` is updated by that edge for a valid read and holds its value until the next valid read. `acc_err` shows the outcome of the access sampled on that edge and is 0 after an edge with no access.

Top module: `dma_glob_regs`

## Requirements
- R1: After reset `rdata` is 0, `acc_err` is 0, `irq` is 0, the master enable is 0 and the status word is 0.
- R2: A byte read (size code 0) at offset 0x00 returns the parameter NCHAN. Any write to offset 0x00 sets `acc_err` and changes no state.
- R3: A byte read at offset 0x01 returns the parameter XFER_CAP. Any write to offset 0x01 sets `acc_err` and changes no state.
- R4: A byte read at offset 0x03 returns the master enable in bit 0, with all other bits 0, and clears the master enable on the same edge.
- R5: A byte write at offset 0x03 loads the master enable from `wdata[0]` and ignores the other data bits.
- R6: A word read (size code 2) at offset 0x04 returns the status word and clears it on the same edge. Between such reads, status bits never clear. Writes to offset 0x04 set `acc_err` and change no state.
- R7: A pulse on `attn[i]` sets status bit i. This includes a pulse in the same cycle as a clearing read, and the bit is set after that read.
- R8: `irq` is 1 exactly when the master enable is 1 and the status word is nonzero.
- R9: An access to a mapped offset with a size code other than the register's own (0 for 0x00, 0x01 and 0x03; 2 for 0x04) sets `acc_err`, leaves `rdata` unchanged and has no side effect.
- R10: An access to any other offset, or a cycle with both `rd_en` and `wr_en` set, sets `acc_err` and has no effect.
- R11: Narrow registers appear right-aligned in `rdata`, little-endian, with all unused upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW | Byte offset of the access |
| size | input | 2 | Access size code: 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes |
| wdata | input | 32 | Write data, little-endian |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| attn | input | NCHAN | Per-channel attention pulses |
| rdata | output | 32 | Read data, little-endian |
| acc_err | output | 1 | Error outcome of the access sampled on the last edge |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with NCHAN=4, XFER_CAP=0x0C and an 8-bit offset. It sweeps offsets 0 to 7 against all four size codes and all three strobe combinations (read, write, both), in two passes with different write data and attention patterns. This covers every mapped register at its legal size and at every illegal size, plus the unmapped offsets 2, 5, 6 and 7. With four channels, every attention bit can be pulsed and then seen in the status word. The bench also drives pulses that coincide with clearing reads.

// File: rtl/dma_glob_regs.sv
module dma_glob_regs #(
  parameter int          NCHAN    = 4,
  parameter logic [7:0]  XFER_CAP = 8'h0C,
  parameter int          AW       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [1:0]       size,
  input  logic [31:0]      wdata,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [NCHAN-1:0] attn,
  output logic [31:0]      rdata,
  output logic             acc_err,
  output logic             irq
);

  localparam logic [AW-1:0] OFF_CNT  = AW'(8'h00);
  localparam logic [AW-1:0] OFF_CAP  = AW'(8'h01);
  localparam logic [AW-1:0] OFF_ICTL = AW'(8'h03);
  localparam logic [AW-1:0] OFF_ATTN = AW'(8'h04);
  localparam logic [1:0]    SZ_BYTE  = 2'd0;
  localparam logic [1:0]    SZ_WORD  = 2'd2;
  localparam logic [7:0]    CNT_VAL  = 8'(NCHAN);

  initial assert (NCHAN >= 1 && NCHAN <= 32);

  logic        mie;
  logic [31:0] status;
  logic [31:0] attn_w;

  wire hit_cnt  = addr == OFF_CNT;
  wire hit_cap  = addr == OFF_CAP;
  wire hit_ictl = addr == OFF_ICTL;
  wire hit_attn = addr == OFF_ATTN;
  wire mapped   = hit_cnt | hit_cap | hit_ictl | hit_attn;
  wire size_ok  = hit_attn ? (size == SZ_WORD) : (size == SZ_BYTE);
  wire solo_rd  = rd_en & ~wr_en;
  wire solo_wr  = wr_en & ~rd_en;
  wire rd_ok    = solo_rd & mapped & size_ok;
  wire wr_ok    = solo_wr & hit_ictl & size_ok;
  wire clr_attn = rd_ok & hit_attn;

  assign attn_w = 32'(attn);
  assign irq    = mie & (|status);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else begin
      status <= (clr_attn ? 32'h0 : status) | attn_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mie <= 1'b0;
    end else if (wr_ok) begin
      mie <= wdata[0];
    end else if (rd_ok && hit_ictl) begin
      mie <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata   <= '0;
      acc_err <= 1'b0;
    end else begin
      acc_err <= (rd_en | wr_en) & ~(rd_ok | wr_ok);
      if (rd_ok) begin
        unique case (1'b1)
          hit_cnt:  rdata <= {24'h0, CNT_VAL};
          hit_cap:  rdata <= {24'h0, XFER_CAP};
          hit_ictl: rdata <= {31'h0, mie};
          default:  rdata <= status;
        endcase
      end
    end
  end

  p_ro_write_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (solo_wr && (hit_cnt || hit_cap)) |=> acc_err);

  p_ictl_read_drops_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (solo_rd && hit_ictl && size == SZ_BYTE) |=> !irq);

  p_attn_read_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_attn && attn == '0) |=> !irq);

  p_status_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_attn |=> (($past(status) & ~status) == 32'h0));

  p_pulse_survives_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (attn != '0) |=> ((status & $past(attn_w)) == $past(attn_w)));

  p_size_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && mapped && !size_ok) |=> (acc_err && $stable(rdata)));

  p_unmapped_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && (!mapped || (rd_en && wr_en))) |=> acc_err);

endmodule

// File: tb/dma_glob_regs_test.sv
module dma_glob_regs_test;
  localparam int         NCHAN = 4;
  localparam logic [7:0] CAP   = 8'h0C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  attn = '0;
  logic [31:0] rdata;
  logic        acc_err, irq;

  dma_glob_regs #(.NCHAN(NCHAN), .XFER_CAP(CAP), .AW(8)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .size(size), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .attn(attn),
    .rdata(rdata), .acc_err(acc_err), .irq(irq));

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  logic        m_mie = 1'b0;
  logic [31:0] m_stat = '0, m_rd = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string err_tag(input logic [7:0] a, input logic [1:0] sz, input bit w, input bit r);
    if (w && r) return "R10";
    if (!(a == 0 || a == 1 || a == 3 || a == 4)) return "R10";
    if ((a == 4) ? (sz != 2) : (sz != 0)) return "R9";
    if (w) return (a == 0) ? "R2" : (a == 1) ? "R3" : (a == 4) ? "R6" : "R5";
    return (a == 0) ? "R2" : (a == 1) ? "R3" : (a == 3) ? "R4" : "R6";
  endfunction

  task automatic acc(input logic [7:0] a, input logic [1:0] sz, input bit w, input bit r,
                     input logic [31:0] wd, input logic [3:0] p, input string tg);
    bit legal, ex_err, nm;
    logic [31:0] ex_rd, ns;
    string rt;
    @(negedge clk);
    addr = a; size = sz; wr_en = w; rd_en = r; wdata = wd; attn = p;
    legal = !(w && r) &&
            (((a == 0 || a == 1) && r && sz == 0) || (a == 3 && sz == 0) ||
             (a == 4 && r && sz == 2));
    ex_err = (w || r) && !legal;
    ex_rd = m_rd;
    if (r && legal)
      case (a)
        8'd0: ex_rd = NCHAN;
        8'd1: ex_rd = {24'h0, CAP};
        8'd3: ex_rd = {31'h0, m_mie};
        default: ex_rd = m_stat;
      endcase
    ns = ((r && legal && a == 4) ? 32'h0 : m_stat) | 32'(p);
    nm = m_mie;
    if (legal && w && a == 3) nm = wd[0];
    else if (legal && r && a == 3) nm = 1'b0;
    m_stat = ns; m_mie = nm; m_rd = ex_rd;
    @(negedge clk);
    rt = (tg != "") ? tg : (a == 0) ? "R2" : (a == 1) ? "R3" : (a == 3) ? "R4" : (a == 4) ? "R6" : "R9";
    check((tg != "") ? tg : err_tag(a, sz, w, r), 32'(acc_err), 32'(ex_err));
    check(rt, rdata, ex_rd);
    check((tg != "") ? tg : "R8", 32'(irq), 32'(m_mie && (m_stat != 0)));
    wr_en = 1'b0; rd_en = 1'b0; attn = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", rdata, 32'h0);
    check("R1", 32'(acc_err), 0);
    check("R1", 32'(irq), 0);
    acc(8'h04, 2'd2, 0, 1, 0, 4'h0, "R1");
    acc(8'h03, 2'd0, 0, 1, 0, 4'h0, "R1");

    acc(8'h00, 2'd0, 0, 1, 0, 4'h0, "R11");
    check("R11", {24'h0, rdata[7:0]}, rdata);
    acc(8'h03, 2'd0, 1, 0, 32'hFFFF_FFFE, 4'h0, "R5");
    acc(8'h03, 2'd0, 0, 1, 0, 4'h0, "R5");
    acc(8'h03, 2'd0, 1, 0, 32'h0000_0001, 4'h0, "R5");
    acc(8'h00, 2'd0, 1, 0, 32'hFF, 4'h2, "R8");
    acc(8'h04, 2'd2, 0, 1, 0, 4'h5, "R7");
    acc(8'h04, 2'd2, 0, 1, 0, 4'h0, "R7");
    check("R7", rdata, 32'h5);
    acc(8'h03, 2'd0, 0, 1, 0, 4'h8, "R4");
    acc(8'h04, 2'd2, 1, 0, 32'hFFFF_FFFF, 4'h0, "R6");
    acc(8'h04, 2'd2, 0, 1, 0, 4'h0, "R6");

    for (int pass = 0; pass < 2; pass++)
      for (int a = 0; a < 8; a++)
        for (int sz = 0; sz < 4; sz++)
          for (int op = 0; op < 3; op++) begin
            logic [31:0] wd;
            logic [3:0]  p;
            wd = 32'h5A5A_5A00 | 32'((pass + a + op) & 1) | (pass != 0 ? 32'hFFFF_0000 : 32'h0);
            p  = (pass != 0) ? 4'((a * 3 + sz + op) & 15) : 4'((a == 4 && op == 0) ? 1 : 0);
            acc(8'(a), 2'(sz), op != 0, op != 1, wd, p, "");
          end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule